// File: doc/BRIEF.md
# Reset Request Arbiter with Sticky Cause Flags

This block merges every reset request on a chip into one system reset line. The requests come from an external active-low pin, a software reset strobe, a watchdog time-out, a conflict between two hard traps, a mismatch between protected pin-routing registers and their shadow copies, and three illegal-condition events. Each cause sets its own bit in a 16-bit cause register. The bit stays set until software clears it with a write-zero, so firmware can read the register after the restart to find out why the restart happened.

The external pin passes through a two-flop synchronizer and a saturating low-time counter. Short glitches are therefore discarded. A watchdog time-out while the core is in a low-power state produces a one-cycle wake pulse and no reset. A small clock-select register is cleared only by the power-on reset, so the selected clock survives every reset this block issues. The power-on reset `por_n` is asynchronous and active low, and it clears all state.

Top module: `reset_cause_ctrl`

## Requirements
- R1: A low level on `ext_pin_n` that lasts 4 or more clock samples asserts `sys_rst` and sets cause bit 7. A low level of 3 samples or fewer has no effect on `sys_rst` or on `cause`. `sys_rst` rises on the 6th clock edge after the pin first falls.
- R2: After a valid pin reset, `sys_rst` stays high while the pin is low. It falls on the 3rd clock edge after the pin returns high.
- R3: A one-cycle `sw_reset_req` sets cause bit 6 and holds `sys_rst` high for exactly 2 cycles, starting at the next clock edge.
- R4: `wdt_timeout` with `low_power` low drives `sys_rst` high in the same cycle, with no clock edge in between. It sets cause bit 4, and `sys_rst` then stays high for 2 cycles after the edge.
- R5: `wdt_timeout` with `low_power` high produces `wake` high for exactly one cycle after the next edge. It does not assert `sys_rst` and does not set cause bit 4.
- R6: A trap conflict is a `trap_valid` strobe where both `trap_level` and `active_level` lie in the range 13 to 15 and `trap_level` is lower than `active_level`. A conflict resets the system and sets cause bit 15. Any other combination of levels has no effect.
- R7: Any difference between `cfg_live` and `cfg_shadow` resets the system and sets cause bit 9.
- R8: Each of the following resets the system and sets cause bit 14: a valid fetch whose `fetch_word[23:16]` equals 0x3F, an uninitialized working-register access, or a security violation. A fetch with any other upper byte has no effect.
- R9: Cause bits are sticky. A write with `cause_wr_en` clears exactly those bits where `cause_wr_data` is 0. Data bits of 1 leave the flag unchanged. A flag being set in the same cycle as a clear ends up set.
- R10: Sources that fire in the same cycle set all of their flags together and produce one reset pulse of exactly 2 cycles.
- R11: `clk_sel` changes only through `clk_sel_wr` or `por_n`. It holds its value through every reset that this block issues.
- R12: After `por_n`, `cause`, `clk_sel`, `sys_rst` and `wake` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_pin_n | input | 1 | Raw external reset pin, active low |
| sw_reset_req | input | 1 | Software reset strobe |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| low_power | input | 1 | Core is in sleep or idle |
| trap_valid | input | 1 | Incoming trap strobe |
| trap_level | input | 4 | Priority of the incoming trap |
| active_level | input | 4 | Priority of the trap being serviced |
| cfg_live | input | CFG_W | Protected pin-routing register contents |
| cfg_shadow | input | CFG_W | Hardware shadow copy of those registers |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_word | input | 24 | Fetched instruction word |
| uninit_w_access | input | 1 | Uninitialized working-register access strobe |
| security_viol | input | 1 | Security violation strobe |
| cause_wr_en | input | 1 | Cause register write strobe |
| cause_wr_data | input | 16 | Write data; a 0 bit clears the flag |
| clk_sel_wr | input | 1 | Clock-select write strobe |
| clk_sel_din | input | CLK_SEL_W | Clock-select write data |
| cause | output | 16 | Sticky reset cause flags |
| clk_sel | output | CLK_SEL_W | Held clock-select value |
| sys_rst | output | 1 | System reset, active high |
| wake | output | 1 | Wake pulse for a low-power watchdog time-out |

## Verification
A wrong flag mapping or a wrong clear mask shows on `cause` one edge after the stimulus. The bench compares `cause` against its model on every cycle of a random run, so such a fault is reported within that cycle. A faulty pulse counter or glitch filter shows as a `sys_rst` that is one cycle too long or too short, or that rises a cycle early or late. The directed cases sample `sys_rst` on each cycle of those windows. A watchdog time-out routed the wrong way between reset and wake shows on `sys_rst` within the same cycle.

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl #(
  parameter int FILT_CYCLES = 4,
  parameter int MIN_PULSE   = 2,
  parameter int CFG_W       = 8,
  parameter int CLK_SEL_W   = 3
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 ext_pin_n,
  input  logic                 sw_reset_req,
  input  logic                 wdt_timeout,
  input  logic                 low_power,
  input  logic                 trap_valid,
  input  logic [3:0]           trap_level,
  input  logic [3:0]           active_level,
  input  logic [CFG_W-1:0]     cfg_live,
  input  logic [CFG_W-1:0]     cfg_shadow,
  input  logic                 fetch_valid,
  input  logic [23:0]          fetch_word,
  input  logic                 uninit_w_access,
  input  logic                 security_viol,
  input  logic                 cause_wr_en,
  input  logic [15:0]          cause_wr_data,
  input  logic                 clk_sel_wr,
  input  logic [CLK_SEL_W-1:0] clk_sel_din,
  output logic [15:0]          cause,
  output logic [CLK_SEL_W-1:0] clk_sel,
  output logic                 sys_rst,
  output logic                 wake
);

  localparam int FCW = $clog2(FILT_CYCLES + 1);
  localparam int PCW = $clog2(MIN_PULSE + 1);
  localparam int B_TRAP = 15;
  localparam int B_ILL  = 14;
  localparam int B_CFG  = 9;
  localparam int B_EXT  = 7;
  localparam int B_SW   = 6;
  localparam int B_WDT  = 4;
  localparam logic [3:0] HARD_MIN = 4'd13;
  localparam logic [7:0] BAD_OP   = 8'h3F;

  logic [1:0]     pin_sync;
  logic [FCW-1:0] low_cnt;
  logic [PCW-1:0] hold_cnt;
  logic [15:0]    set_mask;

  wire pin_low    = !pin_sync[1];
  wire ext_active = (low_cnt == FCW'(FILT_CYCLES));
  wire ext_fire   = pin_low && (low_cnt == FCW'(FILT_CYCLES - 1));
  wire wdt_rst    = wdt_timeout && !low_power;
  wire trap_fire  = trap_valid && (trap_level >= HARD_MIN) &&
                    (active_level >= HARD_MIN) && (trap_level < active_level);
  wire cfg_fire   = (cfg_live != cfg_shadow);
  wire ill_fire   = (fetch_valid && fetch_word[23:16] == BAD_OP) ||
                    uninit_w_access || security_viol;
  wire any_fire   = |set_mask;

  always_comb begin
    set_mask         = '0;
    set_mask[B_TRAP] = trap_fire;
    set_mask[B_ILL]  = ill_fire;
    set_mask[B_CFG]  = cfg_fire;
    set_mask[B_EXT]  = ext_fire;
    set_mask[B_SW]   = sw_reset_req;
    set_mask[B_WDT]  = wdt_rst;
  end

  assign sys_rst = (hold_cnt != '0) || ext_active || wdt_rst;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pin_sync <= 2'b11;
      low_cnt  <= '0;
      hold_cnt <= '0;
      cause    <= '0;
      clk_sel  <= '0;
      wake     <= 1'b0;
    end else begin
      pin_sync <= {pin_sync[0], ext_pin_n};
      if (!pin_low)        low_cnt <= '0;
      else if (!ext_active) low_cnt <= low_cnt + 1'b1;
      if (any_fire)              hold_cnt <= PCW'(MIN_PULSE);
      else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
      cause <= (cause_wr_en ? (cause & cause_wr_data) : cause) | set_mask;
      if (clk_sel_wr) clk_sel <= clk_sel_din;
      wake <= wdt_timeout && low_power;
    end
  end

  a_r3_reset_follows_event: assert property (@(posedge clk) disable iff (!por_n)
    any_fire |=> sys_rst);

  a_r10_min_width: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst) |=> sys_rst);

  a_r5_wake_pulse: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_timeout && low_power) |=> wake);

  a_r5_no_wdt_flag: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_timeout && low_power && !cause[B_WDT] && !cause_wr_en) |=> !cause[B_WDT]);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!por_n)
    !cause_wr_en |=> ((cause & $past(cause)) == $past(cause)));

  a_r11_clksel_held: assert property (@(posedge clk) disable iff (!por_n)
    !clk_sel_wr |=> $stable(clk_sel));

endmodule

// File: tb/reset_cause_ctrl_tb_top.sv
module reset_cause_ctrl_tb_top;
  localparam int CFG_W = 8;
  localparam int CSW = 3;

  logic clk = 1'b0;
  logic por_n, ext_pin_n, sw_reset_req, wdt_timeout, low_power, trap_valid;
  logic [3:0] trap_level, active_level;
  logic [CFG_W-1:0] cfg_live, cfg_shadow;
  logic fetch_valid, uninit_w_access, security_viol, cause_wr_en, clk_sel_wr;
  logic [23:0] fetch_word;
  logic [15:0] cause_wr_data, cause;
  logic [CSW-1:0] clk_sel_din, clk_sel;
  logic sys_rst, wake;
  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [15:0] exp_cause;

  always #4 clk = ~clk;

  reset_cause_ctrl #(.CFG_W(CFG_W), .CLK_SEL_W(CSW)) dut_i (
    .clk(clk), .por_n(por_n), .ext_pin_n(ext_pin_n), .sw_reset_req(sw_reset_req),
    .wdt_timeout(wdt_timeout), .low_power(low_power), .trap_valid(trap_valid),
    .trap_level(trap_level), .active_level(active_level), .cfg_live(cfg_live),
    .cfg_shadow(cfg_shadow), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .uninit_w_access(uninit_w_access), .security_viol(security_viol),
    .cause_wr_en(cause_wr_en), .cause_wr_data(cause_wr_data), .clk_sel_wr(clk_sel_wr),
    .clk_sel_din(clk_sel_din), .cause(cause), .clk_sel(clk_sel), .sys_rst(sys_rst),
    .wake(wake));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic idle();
    sw_reset_req = 0; wdt_timeout = 0; trap_valid = 0; fetch_valid = 0;
    uninit_w_access = 0; security_viol = 0; cause_wr_en = 0; clk_sel_wr = 0;
    cfg_live = cfg_shadow;
  endtask

  task automatic clear_all();
    cause_wr_en = 1; cause_wr_data = 16'h0000; tick(); cause_wr_en = 0;
    repeat (3) tick();
  endtask

  function automatic logic [15:0] model_mask(
      input logic sw, input logic wdt, input logic lp, input logic tv,
      input logic [3:0] tl, input logic [3:0] al, input logic cfg_diff,
      input logic fv, input logic [23:0] fw, input logic uw, input logic sv);
    logic [15:0] m = '0;
    m[15] = tv && tl >= 13 && al >= 13 && tl < al;
    m[14] = (fv && fw[23:16] == 8'h3F) || uw || sv;
    m[9]  = cfg_diff;
    m[6]  = sw;
    m[4]  = wdt && !lp;
    return m;
  endfunction

  task automatic pulse_check(input string req);
    check({req, " rst cycle1"}, sys_rst, 1);
    tick(); check({req, " rst cycle2"}, sys_rst, 1);
    tick(); check({req, " rst released"}, sys_rst, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    por_n = 0; ext_pin_n = 1; low_power = 0; trap_level = 0; active_level = 0;
    cfg_shadow = 8'h5A; cause_wr_data = 0; clk_sel_din = 0; fetch_word = 0;
    idle();
    repeat (3) tick();
    por_n = 1; tick();
    // R12 reset state
    check("R12 cause", cause, 0); check("R12 sys_rst", sys_rst, 0);
    check("R12 wake", wake, 0);   check("R12 clk_sel", clk_sel, 0);

    clk_sel_wr = 1; clk_sel_din = 3'd5; tick(); clk_sel_wr = 0;
    check("R11 clk_sel write", clk_sel, 5);

    // R3 software reset
    sw_reset_req = 1; tick(); sw_reset_req = 0;
    check("R3 flag bit6", cause, 16'h0040);
    pulse_check("R3");
    check("R11 clk_sel kept after sw reset", clk_sel, 5);

    // R9 write of ones has no effect, zero clears
    cause_wr_en = 1; cause_wr_data = 16'hFFFF; tick();
    check("R9 write ones", cause, 16'h0040);
    cause_wr_data = 16'hFFBF; tick(); cause_wr_en = 0;
    check("R9 clear bit6", cause, 0);

    // R4 watchdog, normal mode
    wdt_timeout = 1; low_power = 0; #1;
    check("R4 async assert", sys_rst, 1);
    tick(); wdt_timeout = 0;
    check("R4 flag bit4", cause, 16'h0010);
    pulse_check("R4");
    check("R11 clk_sel kept after wdt reset", clk_sel, 5);
    clear_all();

    // R5 watchdog in low power
    wdt_timeout = 1; low_power = 1; #1;
    check("R5 no async reset", sys_rst, 0);
    tick(); wdt_timeout = 0;
    check("R5 wake", wake, 1); check("R5 no reset", sys_rst, 0);
    check("R5 no flag", cause, 0);
    tick(); check("R5 wake one cycle", wake, 0);
    low_power = 0;

    // R6 trap conflict
    trap_valid = 1; trap_level = 13; active_level = 15; tick(); trap_valid = 0;
    check("R6 conflict flag", cause, 16'h8000); pulse_check("R6");
    clear_all();
    trap_valid = 1; trap_level = 14; active_level = 13; tick(); trap_valid = 0;
    check("R6 higher incoming ignored", {cause, 15'd0, sys_rst}, 0);
    trap_valid = 1; trap_level = 13; active_level = 0; tick(); trap_valid = 0;
    check("R6 no active hard trap", {cause, 15'd0, sys_rst}, 0);
    trap_valid = 1; trap_level = 12; active_level = 14; tick(); trap_valid = 0;
    check("R6 soft incoming ignored", {cause, 15'd0, sys_rst}, 0);

    // R7 config mismatch
    cfg_live = cfg_shadow ^ 8'h10; tick(); cfg_live = cfg_shadow;
    check("R7 mismatch flag", cause, 16'h0200); pulse_check("R7");
    clear_all();

    // R8 illegal conditions
    fetch_valid = 1; fetch_word = 24'h3F1234; tick(); fetch_valid = 0;
    check("R8 illegal opcode", cause, 16'h4000); pulse_check("R8");
    clear_all();
    fetch_valid = 1; fetch_word = 24'h3E1234; tick(); fetch_valid = 0;
    check("R8 legal opcode ignored", {cause, 15'd0, sys_rst}, 0);
    uninit_w_access = 1; tick(); uninit_w_access = 0;
    check("R8 uninit access", cause, 16'h4000); clear_all();
    security_viol = 1; tick(); security_viol = 0;
    check("R8 security", cause, 16'h4000); clear_all();

    // R10 simultaneous sources
    sw_reset_req = 1; trap_valid = 1; trap_level = 14; active_level = 15;
    uninit_w_access = 1; tick(); idle();
    check("R10 all flags", cause, 16'hC040); pulse_check("R10");

    // R9 set wins over clear
    cause_wr_en = 1; cause_wr_data = 0; sw_reset_req = 1; tick(); idle();
    check("R9 set beats clear", cause, 16'h0040);
    clear_all();

    // R1 glitch of 3 samples
    ext_pin_n = 0;
    for (int i = 0; i < 3; i++) begin tick(); check("R1 glitch no reset", sys_rst, 0); end
    ext_pin_n = 1;
    for (int i = 0; i < 5; i++) begin tick(); check("R1 glitch no reset", sys_rst, 0); end
    check("R1 glitch no flag", cause, 0);

    // R1 / R2 valid pin reset
    ext_pin_n = 0;
    repeat (5) tick();
    check("R1 not yet", sys_rst, 0);
    tick(); check("R1 asserted", sys_rst, 1);
    check("R1 flag bit7", cause, 16'h0080);
    repeat (6) tick();
    check("R2 held while low", sys_rst, 1);
    ext_pin_n = 1;
    repeat (2) tick(); check("R2 still held", sys_rst, 1);
    tick(); check("R2 released", sys_rst, 0);
    check("R11 clk_sel kept after pin reset", clk_sel, 5);
    clear_all();

    // Random phase: R9 model of sticky flags, R3 reset follow-up, R5 wake
    exp_cause = cause;
    for (int i = 0; i < 600; i++) begin
      logic [15:0] m;
      logic lp_now, wdt_now;
      sw_reset_req    = ($urandom % 12) == 0;
      wdt_timeout     = ($urandom % 12) == 0;
      low_power       = $urandom % 2;
      trap_valid      = ($urandom % 6) == 0;
      trap_level      = 4'(11 + $urandom % 5);
      active_level    = 4'(11 + $urandom % 5);
      cfg_live        = (($urandom % 15) == 0) ? cfg_shadow ^ 8'h01 : cfg_shadow;
      fetch_valid     = $urandom % 2;
      fetch_word      = (($urandom % 8) == 0) ? {8'h3F, 16'(i)} : {8'h12, 16'(i)};
      uninit_w_access = ($urandom % 20) == 0;
      security_viol   = ($urandom % 25) == 0;
      cause_wr_en     = ($urandom % 4) == 0;
      cause_wr_data   = 16'($urandom);
      m = model_mask(sw_reset_req, wdt_timeout, low_power, trap_valid, trap_level,
                     active_level, cfg_live != cfg_shadow, fetch_valid, fetch_word,
                     uninit_w_access, security_viol);
      exp_cause = (cause_wr_en ? (exp_cause & cause_wr_data) : exp_cause) | m;
      lp_now = low_power; wdt_now = wdt_timeout;
      tick();
      check("R9 random cause", cause, exp_cause);
      if (m != 0) check("R3 random reset after event", sys_rst, 1);
      check("R5 random wake", wake, wdt_now && lp_now);
    end
    idle();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule